// File: doc/BRIEF.md
# Paged Monochrome LCD Framebuffer Controller

This block holds the picture for a 128 by 64 one-bit-per-pixel display and presents it to the rest of the chip in two ways. A host writes the picture through a small 32-bit register window. A display scanner reads it back through a pixel port that returns a 24-bit colour for any (x, y) position. The display memory is organised as eight horizontal pages, and each page is 128 bytes wide. Each byte covers eight vertically stacked pixels in one column.

The host picks one of two transfer modes by writing a mode word. Only two exact magic values are accepted as a mode word. In data mode, each write to the data register stores one byte at the current page and column, and then moves the column one step to the right. The column wraps within the page. In command mode, a write to the data register is read as a page-select command. A separate instruction register always takes page-select commands, whatever the mode.

Three brightness lines each drive one bit of a brightness level. That level scales the fixed foreground colour before it reaches the pixel port. A word-wide control register is kept as plain storage for the host.

Top module: `mono_lcd_fb`

## Requirements
- R1: After reset the control register reads 0, the mode is invalid, and the page and column are both 0. The first byte written after data mode is entered lands in page 0, column 0.
- R2: The control register at byte offset 0x180 stores any 32-bit value written and returns it on reads. Reads of every other offset return 0.
- R3: A write to offset 0x1AC selects data mode for the value 0x00100011 and command mode for the value 0x00104011. Any other value makes the mode invalid.
- R4: A write to offset 0x1BC with a value from 0xB0 to 0xB7 selects page (value - 0xB0) and sets the column to 0. Any other value leaves the page and column unchanged.
- R5: In data mode, a write to offset 0x1C0 stores bits [7:0] at byte address page*128 + column and then increments the column.
- R6: The column wraps from 127 to 0 and the page does not change.
- R7: In command mode, a write to offset 0x1C0 behaves like an instruction write (R4) and stores nothing.
- R8: In invalid mode, writes to offset 0x1C0 change neither the display memory nor the page or column.
- R9: Pixel (x, y) is bit (y mod 8) of byte x + (y/8)*128. The pixel port output reflects the address sampled one clock earlier. A clear pixel outputs 0x000000.
- R10: A set pixel outputs the foreground 0xE0E0FF (bits [23:16] red, [15:8] green, [7:0] blue), with each channel scaled: the full value at brightness 7, 0 at brightness 0, and otherwise channel*brightness/7, truncated.
- R11: The brightness resets to 7. Bit i of the brightness follows line i one clock later, and a change on one line alters only its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte offset of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| bright_line | input | 3 | Brightness lines, one per level bit |
| pix_x | input | 7 | Pixel column to read |
| pix_y | input | 6 | Pixel row to read |
| pix_rgb | output | 24 | Scaled colour of the pixel addressed on the previous clock |

## Verification
The hardest state to reach is the column wrap. To get there, the host must first select a page and then issue 128 data-mode writes in sequence, and only the 129th write shows whether the pointer returned to column 0 of the same page or spilled into the next page. The stimulus fills page 7 with a known pattern after placing a marker byte in page 6, then checks both the overwritten column 0 and the untouched marker. The invalid-mode case is also hard to see, because the mode cannot be read back. A data write made in that mode is therefore followed by a return to data mode and a further write, and the bench checks which column that write reaches.

// File: rtl/lcdfb_pkg.sv
package lcdfb_pkg;

    localparam int COLS      = 128;
    localparam int PAGES     = 8;
    localparam int ROWS      = PAGES * 8;
    localparam int COL_W     = $clog2(COLS);
    localparam int PAGE_W    = $clog2(PAGES);
    localparam int Y_W       = $clog2(ROWS);
    localparam int VADDR_W   = COL_W + PAGE_W;
    localparam int DEPTH     = COLS * PAGES;
    localparam int BUS_AW    = 12;
    localparam int BUS_DW    = 32;
    localparam int BRIGHT_W  = 3;
    localparam int CHANS     = 3;

    localparam logic [BUS_AW-1:0] OFS_CTRL  = 12'h180;
    localparam logic [BUS_AW-1:0] OFS_MODE  = 12'h1AC;
    localparam logic [BUS_AW-1:0] OFS_INSTR = 12'h1BC;
    localparam logic [BUS_AW-1:0] OFS_DATA  = 12'h1C0;

    localparam logic [BUS_DW-1:0] MAGIC_DATA = 32'h0010_0011;
    localparam logic [BUS_DW-1:0] MAGIC_CMD  = 32'h0010_4011;
    localparam logic [BUS_DW-1:0] PAGE_CMD_LO = 32'h0000_00B0;
    localparam logic [BUS_DW-1:0] PAGE_CMD_HI = PAGE_CMD_LO + BUS_DW'(PAGES - 1);

    localparam logic [23:0] FG_COLOR = 24'hE0E0FF;
    localparam logic [BRIGHT_W-1:0] BRIGHT_MAX = '1;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_DATA = 2'd1,
        MODE_CMD  = 2'd2
    } mode_e;

    typedef struct packed {
        logic               en;
        logic [VADDR_W-1:0] addr;
        logic [7:0]         dat;
    } vram_wr_t;

    function automatic logic is_page_cmd(input logic [BUS_DW-1:0] v);
        return (v >= PAGE_CMD_LO) && (v <= PAGE_CMD_HI);
    endfunction

    function automatic logic [PAGE_W-1:0] page_of(input logic [BUS_DW-1:0] v);
        logic [BUS_DW-1:0] d;
        d = v - PAGE_CMD_LO;
        return d[PAGE_W-1:0];
    endfunction

    function automatic logic [7:0] scale_chan(input logic [7:0] c,
                                              input logic [BRIGHT_W-1:0] b);
        logic [10:0] prod;
        logic [10:0] quot;
        prod = {3'b000, c} * {8'h00, b};
        quot = prod / 11'd7;
        if (b == BRIGHT_MAX) return c;
        else if (b == '0)    return 8'h00;
        else                 return quot[7:0];
    endfunction

endpackage

// File: rtl/lcdfb_regif.sv
module lcdfb_regif
    import lcdfb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [BUS_DW-1:0]   bus_wdata,
    output logic [BUS_DW-1:0]   bus_rdata,
    output vram_wr_t            wr,
    output mode_e               mode_o,
    output logic [PAGE_W-1:0]   page_o,
    output logic [COL_W-1:0]    col_o,
    output logic [BUS_DW-1:0]   ctrl_o
);

    mode_e              mode_q;
    logic [PAGE_W-1:0]  page_q;
    logic [COL_W-1:0]   col_q;
    logic [BUS_DW-1:0]  ctrl_q;
    logic               wr_acc;
    logic               page_hit;
    logic               store_byte;

    assign wr_acc     = bus_valid && bus_write;
    assign page_hit   = is_page_cmd(bus_wdata);
    assign store_byte = wr_acc && (bus_addr == OFS_DATA) && (mode_q == MODE_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            page_q <= '0;
            col_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_acc) begin
            case (bus_addr)
                OFS_CTRL: ctrl_q <= bus_wdata;
                OFS_MODE: begin
                    if (bus_wdata == MAGIC_DATA)     mode_q <= MODE_DATA;
                    else if (bus_wdata == MAGIC_CMD) mode_q <= MODE_CMD;
                    else                             mode_q <= MODE_OFF;
                end
                OFS_INSTR: begin
                    if (page_hit) begin
                        page_q <= page_of(bus_wdata);
                        col_q  <= '0;
                    end
                end
                OFS_DATA: begin
                    if (mode_q == MODE_CMD) begin
                        if (page_hit) begin
                            page_q <= page_of(bus_wdata);
                            col_q  <= '0;
                        end
                    end else if (mode_q == MODE_DATA) begin
                        col_q <= col_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr.en   = store_byte;
        wr.addr = {page_q, col_q};
        wr.dat  = bus_wdata[7:0];
    end

    assign bus_rdata = (bus_valid && !bus_write && bus_addr == OFS_CTRL) ? ctrl_q : '0;
    assign mode_o    = mode_q;
    assign page_o    = page_q;
    assign col_o     = col_q;
    assign ctrl_o    = ctrl_q;

endmodule

// File: rtl/lcdfb_vram.sv
module lcdfb_vram
    import lcdfb_pkg::*;
(
    input  logic                clk,
    input  vram_wr_t            wr,
    input  logic [VADDR_W-1:0]  rd_addr,
    output logic [7:0]          rd_byte
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr.en) mem[wr.addr] <= wr.dat;
        rd_byte <= mem[rd_addr];
    end

endmodule

// File: rtl/lcdfb_shade.sv
module lcdfb_shade
    import lcdfb_pkg::*;
(
    input  logic                 lit,
    input  logic [BRIGHT_W-1:0]  level,
    output logic [CHANS*8-1:0]   rgb
);

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
        assign rgb[ch*8 +: 8] = lit ? scale_chan(FG_COLOR[ch*8 +: 8], level) : 8'h00;
    end

endmodule

// File: rtl/mono_lcd_fb.sv
module mono_lcd_fb
    import lcdfb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [BRIGHT_W-1:0]  bright_line,
    input  logic [COL_W-1:0]     pix_x,
    input  logic [Y_W-1:0]       pix_y,
    output logic [CHANS*8-1:0]   pix_rgb
);

    vram_wr_t              wr_w;
    mode_e                 mode_w;
    logic [PAGE_W-1:0]     page_w;
    logic [COL_W-1:0]      col_w;
    logic [BUS_DW-1:0]     ctrl_w;
    logic [BRIGHT_W-1:0]   bright_q;
    logic [BRIGHT_W-1:0]   level_q;
    logic [2:0]            bitsel_q;
    logic [7:0]            rd_byte;
    logic [VADDR_W-1:0]    rd_addr;

    lcdfb_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wr        (wr_w),
        .mode_o    (mode_w),
        .page_o    (page_w),
        .col_o     (col_w),
        .ctrl_o    (ctrl_w)
    );

    for (genvar i = 0; i < BRIGHT_W; i++) begin : g_bright
        always_ff @(posedge clk) begin
            if (rst) bright_q[i] <= 1'b1;
            else     bright_q[i] <= bright_line[i];
        end
    end

    assign rd_addr = {pix_y[Y_W-1:3], pix_x};

    lcdfb_vram u_vram (
        .clk     (clk),
        .wr      (wr_w),
        .rd_addr (rd_addr),
        .rd_byte (rd_byte)
    );

    always_ff @(posedge clk) begin
        bitsel_q <= pix_y[2:0];
        level_q  <= bright_q;
    end

    lcdfb_shade u_shade (
        .lit   (rd_byte[bitsel_q]),
        .level (level_q),
        .rgb   (pix_rgb)
    );

endmodule

// File: rtl/lcdfb_checks.sv
module lcdfb_checks
    import lcdfb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bus_valid,
    input logic                bus_write,
    input logic [BUS_AW-1:0]   bus_addr,
    input logic [BUS_DW-1:0]   bus_wdata,
    input logic [BUS_DW-1:0]   bus_rdata,
    input mode_e               mode,
    input logic [PAGE_W-1:0]   page,
    input logic [COL_W-1:0]    col,
    input logic [BUS_DW-1:0]   ctrl,
    input logic [BRIGHT_W-1:0] bright
);

    logic data_wr;
    assign data_wr = bus_valid && bus_write && (bus_addr == OFS_DATA);

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (ctrl == '0 && page == '0 && col == '0 && mode == MODE_OFF));

    p_other_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && bus_addr != OFS_CTRL) |-> bus_rdata == '0);

    p_bad_mode_word_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == OFS_MODE &&
         bus_wdata != MAGIC_DATA && bus_wdata != MAGIC_CMD) |=> mode == MODE_OFF);

    p_page_select_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && bus_addr == OFS_INSTR && is_page_cmd(bus_wdata))
        |=> (page == $past(bus_wdata[PAGE_W-1:0]) && col == '0));

    p_col_advance_r5: assert property (@(posedge clk) disable iff (rst)
        (data_wr && mode == MODE_DATA) |=> col == COL_W'($past(col) + 1'b1));

    p_col_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (data_wr && mode == MODE_DATA && col == '1) |=> (col == '0 && $stable(page)));

    p_cmd_data_r7: assert property (@(posedge clk) disable iff (rst)
        (data_wr && mode == MODE_CMD && !is_page_cmd(bus_wdata)) |=> ($stable(page) && $stable(col)));

    p_idle_data_r8: assert property (@(posedge clk) disable iff (rst)
        (data_wr && mode == MODE_OFF) |=> ($stable(page) && $stable(col)));

    p_bright_reset_r11: assert property (@(posedge clk)
        rst |=> bright == BRIGHT_MAX);

endmodule

bind mono_lcd_fb lcdfb_checks u_checks (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode      (mode_w),
    .page      (page_w),
    .col       (col_w),
    .ctrl      (ctrl_w),
    .bright    (bright_q)
);

// File: tb/test_mono_lcd_fb.sv
module test_mono_lcd_fb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  bright_line = 3'd7;
    logic [6:0]  pix_x = '0;
    logic [5:0]  pix_y = '0;
    logic [23:0] pix_rgb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mono_lcd_fb i_mono_lcd_fb (
        .clk         (clk),
        .rst         (rst),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bright_line (bright_line),
        .pix_x       (pix_x),
        .pix_y       (pix_y),
        .pix_rgb     (pix_rgb)
    );

    typedef struct packed {
        logic [11:0] a;
        logic [31:0] d;
        logic        chk;
        logic [6:0]  x;
        logic [5:0]  y;
        logic        on;
        logic [3:0]  req;
    } row_t;

    localparam int NROWS = 17;
    localparam logic [23:0] FULL = 24'hE0E0FF;
    localparam row_t TBL [NROWS] = '{
        '{12'h1AC, 32'h0010_0011, 1'b0, 7'd0, 6'd0,  1'b0, 4'd3}, // R3 data mode
        '{12'h1BC, 32'h0000_00B2, 1'b0, 7'd0, 6'd0,  1'b0, 4'd4}, // R4 page 2
        '{12'h1C0, 32'h0000_0081, 1'b1, 7'd0, 6'd16, 1'b1, 4'd5}, // R5 col 0
        '{12'h1C0, 32'h0000_0002, 1'b1, 7'd1, 6'd17, 1'b1, 4'd5}, // R5 col 1
        '{12'h1BC, 32'h0000_0055, 1'b0, 7'd0, 6'd0,  1'b0, 4'd4}, // R4 ignored
        '{12'h1C0, 32'h0000_0004, 1'b1, 7'd2, 6'd18, 1'b1, 4'd4}, // R4 col kept
        '{12'h1AC, 32'h0010_4011, 1'b0, 7'd0, 6'd0,  1'b0, 4'd3}, // R3 cmd mode
        '{12'h1C0, 32'h0000_00B5, 1'b0, 7'd0, 6'd0,  1'b0, 4'd7}, // R7 page 5
        '{12'h1AC, 32'h0010_0011, 1'b0, 7'd0, 6'd0,  1'b0, 4'd3},
        '{12'h1C0, 32'h0000_00FF, 1'b1, 7'd0, 6'd40, 1'b1, 4'd7}, // R7 landed page 5
        '{12'h1C0, 32'h0000_0000, 1'b1, 7'd1, 6'd40, 1'b0, 4'd5},
        '{12'h1BC, 32'h0000_00B5, 1'b0, 7'd0, 6'd0,  1'b0, 4'd4},
        '{12'h1AC, 32'h0010_0012, 1'b0, 7'd0, 6'd0,  1'b0, 4'd3}, // R3 near-miss
        '{12'h1C0, 32'h0000_0000, 1'b1, 7'd0, 6'd40, 1'b1, 4'd8}, // R8 no store
        '{12'h1AC, 32'h0010_0011, 1'b0, 7'd0, 6'd0,  1'b0, 4'd3},
        '{12'h1C0, 32'h0000_0000, 1'b1, 7'd0, 6'd40, 1'b0, 4'd8}, // R8 col held
        '{12'h1C0, 32'h0000_0080, 1'b1, 7'd1, 6'd47, 1'b1, 4'd5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic pix_rd(input logic [6:0] x, input logic [5:0] y, output logic [23:0] c);
        @(negedge clk);
        pix_x = x; pix_y = y;
        @(negedge clk);
        c = pix_rgb;
    endtask

    function automatic logic [23:0] exp_rgb(input int b);
        logic [23:0] r;
        for (int ch = 0; ch < 3; ch++) begin
            int c;
            c = (FULL >> (ch * 8)) & 255;
            r[ch*8 +: 8] = 8'((c * b) / 7);
        end
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1..: act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rv;
        logic [23:0] c;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state, R2 other offsets
        bus_rd(12'h180, rv); check("R1 ctrl after reset", rv, 0);
        bus_rd(12'h1AC, rv); check("R2 mode offset reads 0", rv, 0);
        bus_wr(12'h180, 32'hDEAD_BEEF);
        bus_rd(12'h180, rv); check("R2 ctrl readback", rv, 32'hDEAD_BEEF);
        bus_rd(12'h184, rv); check("R2 unmapped reads 0", rv, 0);
        bus_rd(12'h1C0, rv); check("R2 data offset reads 0", rv, 0);

        // table walk
        for (int i = 0; i < NROWS; i++) begin
            bus_wr(TBL[i].a, TBL[i].d);
            if (TBL[i].chk) begin
                pix_rd(TBL[i].x, TBL[i].y, c);
                check($sformatf("R%0d table row %0d", TBL[i].req, i), c, TBL[i].on ? FULL : 24'h0);
            end
        end

        // R9 mapping and clear pixels black
        pix_rd(7'd0, 6'd17, c); check("R9 clear bit black", c, 0);
        pix_rd(7'd0, 6'd23, c); check("R9 bit7 of byte", c, FULL);
        pix_rd(7'd1, 6'd16, c); check("R9 neighbour column", c, 0);

        // R6 wrap: marker in page 6, fill page 7 then one more
        bus_wr(12'h1BC, 32'hB6);
        bus_wr(12'h1C0, 32'hAA);
        bus_wr(12'h1BC, 32'hB7);
        for (int k = 0; k < 128; k++) bus_wr(12'h1C0, 32'h01);
        bus_wr(12'h1C0, 32'h80);
        pix_rd(7'd0, 6'd63, c);   check("R6 wrapped write lands col 0", c, FULL);
        pix_rd(7'd0, 6'd56, c);   check("R6 col 0 overwritten", c, 0);
        pix_rd(7'd127, 6'd56, c); check("R6 last column", c, FULL);
        pix_rd(7'd0, 6'd49, c);   check("R6 page 6 marker kept", c, FULL);
        pix_rd(7'd0, 6'd48, c);   check("R6 page 6 marker bit0", c, 0);

        // R7 non-page data in command mode ignored, page data selects
        bus_wr(12'h1AC, 32'h0010_4011);
        bus_wr(12'h1C0, 32'h12);
        bus_wr(12'h1C0, 32'hB3);
        bus_wr(12'h1AC, 32'h0010_0011);
        bus_wr(12'h1C0, 32'h40);
        pix_rd(7'd0, 6'd30, c); check("R7 command page select", c, FULL);

        // R10 scaling over all levels
        for (int b = 0; b < 8; b++) begin
            @(negedge clk); bright_line = 3'(b);
            @(negedge clk);
            pix_rd(7'd0, 6'd30, c);
            check($sformatf("R10 level %0d", b), c, exp_rgb(b));
        end
        // R11 single line change: 7 -> 5
        @(negedge clk); bright_line = 3'd7;
        @(negedge clk); bright_line[1] = 1'b0;
        @(negedge clk);
        pix_rd(7'd0, 6'd30, c); check("R11 one line alters one bit", c, 24'hA0A0B6);
        pix_rd(7'd0, 6'd31, c); check("R10 clear pixel at level 5", c, 0);
        @(negedge clk); bright_line = 3'd7;

        // R1 mid-run reset clears page and column
        bus_wr(12'h1BC, 32'hB3);
        bus_wr(12'h1C0, 32'h11);
        bus_wr(12'h180, 32'h1234);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        bus_rd(12'h180, rv); check("R1 ctrl cleared", rv, 0);
        bus_wr(12'h1C0, 32'hFF);
        bus_wr(12'h1AC, 32'h0010_0011);
        bus_wr(12'h1C0, 32'hF0);
        pix_rd(7'd0, 6'd4, c); check("R1 page0 col0 after reset", c, FULL);
        pix_rd(7'd0, 6'd3, c); check("R1 invalid mode after reset", c, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule